// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block is the digital back end of a flash analog-to-digital converter. A bank of comparators, one for each quantizing threshold, produces a thermometer vector of 2^N−1 lines. These lines change whenever the analog input crosses a threshold, with no reference to any clock. The block captures the vector on the rising clock edge, so that edge is the sampling instant and quantizing happens before sampling. It then passes the vector through a chain of resynchronizing flip-flops.

After resynchronization, a priority encoder finds the highest comparator that reads true. It emits that comparator's position plus one as an N-bit result, so the result equals the number of true comparators in a clean code. A per-sample format bit, captured on the same edge as the comparators, selects the output format. With the bit clear the result is offset binary. With the bit set only the MSB is inverted, which gives two's complement. The result leaves through a short register pipeline together with a valid flag. The flag marks the first sample that has passed through the whole pipeline.

Top module: `flash_therm_enc`

## Requirements
- R1: While reset is held, and after reset until valid_o rises, code_o is all zeros and valid_o is 0.
- R2: A comparator vector with every line false, sampled with fmt_i = 0, encodes as code 0.
- R3: A clean thermometer vector whose lines 0..k−1 are true and whose other lines are false encodes as k in offset binary (line 0 is the lowest threshold).
- R4: A vector with bubbles encodes as i+1, where i is the highest-index true line. The false lines below it do not change the result.
- R5: When fmt_i is 1 at the sampling edge, the result is the offset binary code with bit N−1 inverted and all other bits unchanged. fmt_i = 0 selects offset binary.
- R6: The comparator vector and fmt_i captured at a rising edge appear on code_o after LATENCY rising edges, counting the capturing edge as the first. LATENCY = SYNC_STAGES + PIPE_STAGES. When the inputs are held steady, code_o stays steady.
- R7: valid_o is 1 from the LATENCY-th rising edge after reset release onwards and is 0 before it.
- R8: All lines true encode as 2^N−1 in offset binary, and as 2^(N−1)−1 in two's complement.
- R9: Changes on comp_i and fmt_i between clock edges have no effect. Only the values present at a rising edge are encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; each rising edge takes one sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_i | input | 2^RES_BITS−1 | Comparator lines, bit 0 is the lowest threshold |
| fmt_i | input | 1 | Output format: 0 offset binary, 1 two's complement |
| code_o | output | RES_BITS | Encoded sample |
| valid_o | output | 1 | code_o holds a genuine sample |

## Verification
The bench builds the block with RES_BITS = 4, SYNC_STAGES = 3 and PIPE_STAGES = 2. This gives 15 comparator lines and a latency of five edges. At that size every result code, both extremes and the MSB flip in both directions can be reached many times in a short run. Because the synchronizer is deeper than its minimum, a stage miscount shifts results by a whole sample and cannot hide. The random bubbled and unstructured vectors cover every line position as the highest true input. Injected between-edge glitches test that only edge values count.

// File: rtl/ftenc_pkg.sv
package ftenc_pkg;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } fmt_e;

    function automatic int lines_for(input int bits);
        return (1 << bits) - 1;
    endfunction

endpackage

// File: rtl/ftenc_sync.sv
module ftenc_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[STAGES-1];

endmodule

// File: rtl/ftenc_prio.sv
module ftenc_prio #(
    parameter int RES_BITS = 8,
    localparam int LINES   = (1 << RES_BITS) - 1
) (
    input  logic [LINES-1:0]    therm,
    output logic [RES_BITS-1:0] code
);

    always_comb begin
        code = '0;
        for (int i = 0; i < LINES; i++) begin
            if (therm[i]) begin
                code = RES_BITS'(i + 1);
            end
        end
    end

endmodule

// File: rtl/ftenc_outpipe.sv
module ftenc_outpipe
    import ftenc_pkg::*;
#(
    parameter int RES_BITS = 8,
    parameter int STAGES   = 1,
    parameter int VLEN     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RES_BITS-1:0] enc,
    input  fmt_e                fmt,
    output logic [RES_BITS-1:0] code,
    output logic                valid
);

    localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

    typedef struct packed {
        logic [STAGES-1:0][RES_BITS-1:0] code;
        logic [VLEN-1:0]                 vld;
    } pipe_t;

    pipe_t pp_d, pp_q;

    always_comb begin
        pp_d = pp_q;
        pp_d.code[0] = (fmt == FMT_TWOS) ? (enc ^ MSB_MASK) : enc;
        for (int s = 1; s < STAGES; s++) begin
            pp_d.code[s] = pp_q.code[s-1];
        end
        pp_d.vld = (pp_q.vld << 1) | VLEN'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign code  = pp_q.code[STAGES-1];
    assign valid = pp_q.vld[VLEN-1];

endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
    import ftenc_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PIPE_STAGES = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [(1 << RES_BITS) - 2:0]  comp_i,
    input  logic                          fmt_i,
    output logic [RES_BITS-1:0]           code_o,
    output logic                          valid_o
);

    localparam int LINES   = lines_for(RES_BITS);
    localparam int LATENCY = SYNC_STAGES + PIPE_STAGES;

    logic [LINES:0]      smp;
    logic [RES_BITS-1:0] enc;
    fmt_e                fmt_s;

    ftenc_sync #(
        .WIDTH  (LINES + 1),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({fmt_i, comp_i}),
        .dout  (smp)
    );

    assign fmt_s = fmt_e'(smp[LINES]);

    ftenc_prio #(
        .RES_BITS (RES_BITS)
    ) u_prio (
        .therm (smp[LINES-1:0]),
        .code  (enc)
    );

    ftenc_outpipe #(
        .RES_BITS (RES_BITS),
        .STAGES   (PIPE_STAGES),
        .VLEN     (LATENCY)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .enc   (enc),
        .fmt   (fmt_s),
        .code  (code_o),
        .valid (valid_o)
    );

endmodule

// File: rtl/ftenc_checker.sv
module ftenc_checker #(
    parameter int RES_BITS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PIPE_STAGES = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [(1 << RES_BITS) - 2:0] comp_i,
    input logic                         fmt_i,
    input logic [RES_BITS-1:0]          code_o,
    input logic                         valid_o
);

    localparam int LAT = SYNC_STAGES + PIPE_STAGES;
    localparam int CW  = $clog2(LAT + 2);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [(1 << RES_BITS) - 1:0] prev_q;
    logic [CW-1:0]                same_q;
    logic [CW-1:0]                warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            same_q <= '0;
            warm_q <= '0;
        end else begin
            prev_q <= {fmt_i, comp_i};
            if ({fmt_i, comp_i} != prev_q) begin
                same_q <= '0;
            end else if (same_q < CW'(LAT + 1)) begin
                same_q <= same_q + 1'b1;
            end
            if (warm_q < CW'(LAT + 1)) begin
                warm_q <= warm_q + 1'b1;
            end
        end
    end

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> code_o == '0);

    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    p_valid_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q < CW'(LAT)) |-> !valid_o);

    p_valid_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= CW'(LAT)) |-> valid_o);

    p_all_false_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (same_q >= CW'(LAT) && valid_o && prev_q == '0) |-> code_o == '0);

    p_all_true_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (same_q >= CW'(LAT) && valid_o && !prev_q[(1 << RES_BITS) - 1]
         && &prev_q[(1 << RES_BITS) - 2:0]) |-> &code_o);

    p_msb_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (same_q >= CW'(LAT) && valid_o && prev_q[(1 << RES_BITS) - 1]
         && prev_q[(1 << RES_BITS) - 2:0] == '0) |-> code_o == MSB_ONLY);

    p_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (same_q >= CW'(LAT) && valid_o && $past(valid_o)) |-> $stable(code_o));

endmodule

bind flash_therm_enc ftenc_checker #(
    .RES_BITS    (RES_BITS),
    .SYNC_STAGES (SYNC_STAGES),
    .PIPE_STAGES (PIPE_STAGES)
) u_ftenc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .comp_i  (comp_i),
    .fmt_i   (fmt_i),
    .code_o  (code_o),
    .valid_o (valid_o)
);

// File: tb/test_flash_therm_enc.sv
module test_flash_therm_enc;

    localparam int NB    = 4;
    localparam int NL    = (1 << NB) - 1;
    localparam int LAT   = 5;
    localparam int NS    = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] comp = '0;
    logic          fmt = 1'b0;
    logic [NB-1:0] code;
    logic          valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [NB-1:0] exp_q [NS];
    string         tag_q [NS];

    always #2 clk = ~clk;

    flash_therm_enc #(
        .RES_BITS    (NB),
        .SYNC_STAGES (3),
        .PIPE_STAGES (2)
    ) i_flash_therm_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .comp_i  (comp),
        .fmt_i   (fmt),
        .code_o  (code),
        .valid_o (valid)
    );

    function automatic logic [NB-1:0] model(input logic [NL-1:0] v, input logic f);
        logic [NB-1:0] r = '0;
        for (int i = 0; i < NL; i++) if (v[i]) r = NB'(i + 1);
        if (f) r[NB-1] = ~r[NB-1];
        return r;
    endfunction

    task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pick(input int t, output logic [NL-1:0] v, output logic f,
                        output string tg, output bit glitch);
        int k;
        glitch = 1'b0;
        if (t < 8) begin
            v = '0; f = 1'b0; tg = "R2";
        end else if (t < 16) begin
            v = '1; f = 1'b0; tg = "R8";
        end else if (t < 24) begin
            v = '1; f = 1'b1; tg = "R8";
        end else if (t < 32) begin
            v = '0; f = 1'b1; tg = "R5";
        end else if (t < 48) begin
            v = NL'((1 << (t - 32)) - 1); f = 1'b0; tg = "R3";
        end else if (t < 64) begin
            v = NL'((1 << (t - 48)) - 1); f = 1'b1; tg = "R5";
        end else if (t < 80) begin
            v = NL'((1 << (t - 64)) - 1); f = t[0]; tg = "R6";
        end else begin
            f = 1'(($urandom() >> 3) & 1);
            case ($urandom_range(0, 2))
                0: begin
                    k = $urandom_range(2, NL);
                    v = NL'((1 << k) - 1);
                    v[$urandom_range(0, k - 2)] = 1'b0;
                    tg = "R4";
                end
                1: begin
                    v = NL'($urandom());
                    tg = "R4";
                end
                default: begin
                    k = $urandom_range(0, NL);
                    v = NL'((1 << k) - 1);
                    glitch = 1'b1;
                    tg = "R9";
                end
            endcase
        end
    endtask

    initial begin
        logic [NL-1:0] v;
        logic          f;
        string         tg;
        bit            gl;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset code", code, '0);
        chk("R1 reset valid", NB'(valid), '0);
        for (int t = 0; t < NS + LAT; t++) begin
            @(negedge clk);
            if (t > 0) begin
                chk("R7 valid", NB'(valid), NB'(t >= LAT));
                if (t >= LAT) chk(tag_q[t - LAT], code, exp_q[t - LAT]);
                else          chk("R1 idle code", code, '0);
            end
            if (t == 0) rst_n = 1'b1;
            if (t < NS) begin
                pick(t, v, f, tg, gl);
                exp_q[t] = model(v, f);
                tag_q[t] = tg;
                if (gl) begin
                    comp = ~v;
                    fmt  = ~f;
                    #1;
                end
                comp = v;
                fmt  = f;
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule